// File: doc/BRIEF.md
# SPI One-Time-Programmable Area Read Responder

This block is the device-side logic that answers a read of a small one-time-programmable (OTP) area over a single-line SPI link. A system clock oversamples the chip select, serial clock and serial input pins through a synchronizer. When chip select is low, the block takes an 8-bit opcode, a 24-bit start address and one dummy byte. If the opcode matches and no erase or program cycle is running, it then streams bytes from the OTP area on the serial output line. The address advances by one after each byte.

The storage itself sits outside the block. The block presents a byte address on `otp_addr` and takes the addressed byte back combinationally on `otp_byte`. The address counter never wraps back into the area. Any byte whose address is 65 or above is sent as 0xFF. Both common SPI clock polarities are accepted: clock idling low with data captured on the first edge (mode 0), and clock idling high (mode 3).

Top module: `otp_spi_reader`

## Requirements
- R1: A transaction begins when chip select goes low. The link then carries an 8-bit opcode (default 0x4B), a 24-bit address with its most significant byte first, and one dummy byte. All bits travel most significant bit first and are captured on rising serial clock edges.
- R2: Output bits change only on falling serial clock edges. The most significant bit of the first data byte appears on the falling edge that follows the rising edge carrying the last dummy bit. Data bits go out most significant bit first.
- R3: After each complete output byte, the read address increases by one, and streaming continues for as long as chip select stays low.
- R4: A byte at an address from 0 to 64 carries the OTP content at that address. A byte at any address of 65 or above, including addresses with nonzero upper bytes, reads as 0xFF. The counter never rolls back to 0.
- R5: The output enable `miso_oe` is low while chip select is high and during the opcode, address and dummy phases. It is high during the data phase of an accepted read. The serial output reads 0 after reset.
- R6: Raising chip select ends the transaction at any point, including partway through a data byte. `miso_oe` falls within SYNC_STAGES+2 system clocks of the pin change, and the next transaction starts from a clean opcode phase.
- R7: If `busy` is high on the system clock in which the eighth opcode bit is taken in, the read is rejected. `miso_oe` then stays low until chip select goes high.
- R8: An opcode other than the configured value is ignored. All further serial clocks are disregarded and `miso_oe` stays low until chip select goes high.
- R9: A transaction is decoded the same way whether the serial clock idles low (mode 0) or high (mode 3). A falling edge that comes before the first rising edge is disregarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock |
| mosi | input | 1 | Serial data from the host |
| busy | input | 1 | High while an erase, program or write cycle runs |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Output enable for `miso` (tri-state control) |
| otp_addr | output | 7 | Byte address into the OTP storage |
| otp_byte | input | 8 | Byte read from the OTP storage at `otp_addr` |

## Verification
Each pin change passes through SYNC_STAGES synchronizer flops and one register before it shows at an output. A new `miso` bit is therefore due SYNC_STAGES+1 system clocks after the falling serial clock edge. The bench holds each serial clock level for four system clocks and reads `miso` and `miso_oe` on the clock just before it raises the serial clock, when the bit is certainly settled. When chip select rises, the bench waits SYNC_STAGES+3 clocks before it requires the enable to be low. A per-clock monitor checks that the enable stays low outside the window in which the bench's model allows data. That window opens at the last dummy rising edge and closes after the chip select settling delay.

// File: rtl/otp_spi_pkg.sv
package otp_spi_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_CMD   = 3'd1,
    PH_ADDR  = 3'd2,
    PH_DUMMY = 3'd3,
    PH_DATA  = 3'd4,
    PH_DROP  = 3'd5
  } phase_t;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic cs_n_s,
  output logic mosi_s,
  output logic sck_rise,
  output logic sck_fall
);

  logic [STAGES-1:0] cs_chain_q, cs_chain_d;
  logic [STAGES-1:0] sck_chain_q, sck_chain_d;
  logic [STAGES-1:0] mosi_chain_q, mosi_chain_d;
  logic              sck_last_q;

  always_comb begin
    cs_chain_d   = {cs_chain_q[STAGES-2:0], cs_n};
    sck_chain_d  = {sck_chain_q[STAGES-2:0], sck};
    mosi_chain_d = {mosi_chain_q[STAGES-2:0], mosi};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_chain_q   <= '1;
      sck_chain_q  <= '0;
      mosi_chain_q <= '0;
      sck_last_q   <= 1'b0;
    end else begin
      cs_chain_q   <= cs_chain_d;
      sck_chain_q  <= sck_chain_d;
      mosi_chain_q <= mosi_chain_d;
      sck_last_q   <= sck_chain_q[STAGES-1];
    end
  end

  assign cs_n_s   = cs_chain_q[STAGES-1];
  assign mosi_s   = mosi_chain_q[STAGES-1];
  assign sck_rise = sck_chain_q[STAGES-1] & ~sck_last_q;
  assign sck_fall = ~sck_chain_q[STAGES-1] & sck_last_q;

  AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    sck_rise |=> !sck_rise) else $error("two rises in a row"); // R1

endmodule

// File: rtl/otp_cmd_ctrl.sv
module otp_cmd_ctrl
  import otp_spi_pkg::*;
#(
  parameter int          ADDR_W = 24,
  parameter logic [7:0]  OPCODE = 8'h4B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              mosi_s,
  input  logic              sck_rise,
  input  logic              busy,
  input  logic              byte_adv,
  output phase_t            phase,
  output logic [ADDR_W-1:0] addr
);

  localparam int CNT_W = $clog2(ADDR_W);
  localparam logic [CNT_W-1:0] LAST_BYTE_BIT = CNT_W'(7);
  localparam logic [CNT_W-1:0] LAST_ADDR_BIT = CNT_W'(ADDR_W - 1);

  phase_t            phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [7:0]        op_q, op_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [7:0]        op_next;

  assign op_next = {op_q[6:0], mosi_s};

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    op_d    = op_q;
    addr_d  = addr_q;
    if (cs_n_s) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          phase_d = PH_CMD;
          cnt_d   = '0;
        end
        PH_CMD: if (sck_rise) begin
          op_d = op_next;
          if (cnt_q == LAST_BYTE_BIT) begin
            cnt_d   = '0;
            phase_d = (op_next == OPCODE && !busy) ? PH_ADDR : PH_DROP;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_ADDR: if (sck_rise) begin
          addr_d = {addr_q[ADDR_W-2:0], mosi_s};
          if (cnt_q == LAST_ADDR_BIT) begin
            cnt_d   = '0;
            phase_d = PH_DUMMY;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_DUMMY: if (sck_rise) begin
          if (cnt_q == LAST_BYTE_BIT) begin
            cnt_d   = '0;
            phase_d = PH_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_DATA: if (byte_adv && addr_q != '1) begin
          addr_d = addr_q + 1'b1;
        end
        default: phase_d = PH_DROP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      op_q    <= '0;
      addr_q  <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      op_q    <= op_d;
      addr_q  <= addr_d;
    end
  end

  assign phase = phase_q;
  assign addr  = addr_q;

  AST_CS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> phase_q == PH_IDLE) else $error("cs high not idle"); // R6
  AST_DROP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DROP && !cs_n_s) |=> phase_q == PH_DROP) else $error("left drop"); // R8
  AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_CMD && sck_rise && cnt_q == LAST_BYTE_BIT && busy && !cs_n_s)
    |=> phase_q == PH_DROP) else $error("busy not rejected"); // R7
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DATA && byte_adv && !cs_n_s && addr_q != '1)
    |=> addr_q == $past(addr_q) + 1'b1) else $error("address step"); // R3

endmodule

// File: rtl/otp_tx_bit.sv
module otp_tx_bit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       sck_fall,
  input  logic [7:0] byte_in,
  output logic       miso,
  output logic       byte_adv
);

  logic [2:0] bit_q, bit_d;
  logic       miso_q, miso_d;

  always_comb begin
    bit_d  = bit_q;
    miso_d = miso_q;
    if (!active) begin
      bit_d  = '0;
      miso_d = 1'b0;
    end else if (sck_fall) begin
      miso_d = byte_in[3'd7 - bit_q];
      bit_d  = bit_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= '0;
      miso_q <= 1'b0;
    end else begin
      bit_q  <= bit_d;
      miso_q <= miso_d;
    end
  end

  assign miso     = miso_q;
  assign byte_adv = active && sck_fall && (bit_q == 3'd7);

  AST_MISO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !sck_fall) |=> $stable(miso_q)) else $error("miso moved off falling edge"); // R2

endmodule

// File: rtl/otp_spi_reader.sv
module otp_spi_reader
  import otp_spi_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         ADDR_W      = 24,
  parameter int         OTP_BYTES   = 65,
  parameter logic [7:0] OPCODE      = 8'h4B,
  localparam int        OTP_AW      = $clog2(OTP_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              mosi,
  input  logic              busy,
  output logic              miso,
  output logic              miso_oe,
  output logic [OTP_AW-1:0] otp_addr,
  input  logic [7:0]        otp_byte
);

  localparam logic [ADDR_W-1:0] AREA_END = ADDR_W'(OTP_BYTES);

  logic [1:0]        rst_sync_q;
  logic              rst_n_i;
  logic              cs_n_s, mosi_s, sck_rise, sck_fall;
  logic              byte_adv, data_active;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        tx_byte;
  phase_t            phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_i), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .cs_n_s(cs_n_s), .mosi_s(mosi_s), .sck_rise(sck_rise), .sck_fall(sck_fall)
  );

  otp_cmd_ctrl #(.ADDR_W(ADDR_W), .OPCODE(OPCODE)) u_ctrl (
    .clk(clk), .rst_n(rst_n_i), .cs_n_s(cs_n_s), .mosi_s(mosi_s),
    .sck_rise(sck_rise), .busy(busy), .byte_adv(byte_adv),
    .phase(phase), .addr(addr)
  );

  assign data_active = (phase == PH_DATA);
  assign tx_byte     = (addr < AREA_END) ? otp_byte : 8'hFF;
  assign otp_addr    = addr[OTP_AW-1:0];

  otp_tx_bit u_tx (
    .clk(clk), .rst_n(rst_n_i), .active(data_active), .sck_fall(sck_fall),
    .byte_in(tx_byte), .miso(miso), .byte_adv(byte_adv)
  );

  assign miso_oe = data_active;

  AST_BEYOND_ONES: assert property (@(posedge clk) disable iff (!rst_n_i)
    (data_active && sck_fall && addr >= AREA_END) |=> miso) else $error("beyond area not ones"); // R4
  AST_OE_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n_i)
    (cs_n_s && $past(cs_n_s)) |-> !miso_oe) else $error("oe with cs high"); // R5

endmodule

// File: tb/sim_otp_spi_reader.sv
module sim_otp_spi_reader;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int SYNC       = 2;
  localparam int AREA       = 65;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, busy = 1'b0;
  logic       miso, miso_oe;
  logic [6:0] otp_addr;
  logic [7:0] otp_byte;

  int  total = 0;
  int  bad = 0;
  bit  oe_allowed = 1'b0;
  bit  monitor_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] content(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  function automatic logic [7:0] expect_at(longint a);
    return (a < AREA) ? content(int'(a)) : 8'hFF;
  endfunction

  assign otp_byte = content(int'(otp_addr));

  otp_spi_reader u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .busy(busy),
    .miso(miso), .miso_oe(miso_oe), .otp_addr(otp_addr), .otp_byte(otp_byte)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // per-clock model of the output enable window: R5
  always @(negedge clk) begin
    if (monitor_on && !oe_allowed) check(miso_oe == 1'b0, "R5 oe outside data", miso_oe, 0);
  end

  task automatic xfer(input logic [7:0] op, input logic [23:0] adr, input int nbytes,
                      input bit mode3, input bit accept, input int abort_bits, input string tag);
    logic [39:0] hdr;
    logic [7:0]  rx;
    int          nbits;
    bit          stop;
    hdr   = {op, adr, 8'h00};
    nbits = 0;
    stop  = 1'b0;
    sck = mode3; tick(HALF);
    cs_n = 1'b0; tick(HALF);
    for (int i = 39; i >= 0; i--) begin
      sck = 1'b0; mosi = hdr[i]; tick(HALF);
      check(miso_oe == 1'b0, {tag, " R5 oe in header"}, miso_oe, 0);
      if (i == 0) oe_allowed = accept;
      sck = 1'b1; tick(HALF);
    end
    for (int k = 0; k < nbytes && !stop; k++) begin
      rx = '0;
      for (int j = 7; j >= 0 && !stop; j--) begin
        sck = 1'b0; mosi = 1'b0; tick(HALF);
        check(miso_oe == accept, {tag, " R5/R7/R8 oe in data"}, miso_oe, accept);
        rx[j] = miso;
        sck = 1'b1; tick(HALF);
        nbits++;
        if (nbits == abort_bits) stop = 1'b1;
      end
      if (accept && !stop)
        check(rx == expect_at(longint'(adr) + k), {tag, " R2/R3/R4 data byte"}, rx,
              expect_at(longint'(adr) + k));
    end
    if (!mode3) begin sck = 1'b0; tick(HALF); end
    cs_n = 1'b1;
    tick(SYNC + 3);
    oe_allowed = 1'b0;
    check(miso_oe == 1'b0, {tag, " R6 oe after cs high"}, miso_oe, 0);
    tick(HALF);
  endtask

  initial begin
    tick(5);
    check(miso_oe == 1'b0, "R5 reset oe", miso_oe, 0);
    check(miso == 1'b0, "R5 reset miso", miso, 0);
    rst_n = 1'b1;
    tick(6);
    monitor_on = 1'b1;
    // R1 R2 R3 R9: mode 0 read from the middle of the area
    xfer(8'h4B, 24'h000005, 3, 1'b0, 1'b1, -1, "R1 mode0");
    // R9 R4 R3: mode 3 read crossing the end of the area
    xfer(8'h4B, 24'h00003E, 5, 1'b1, 1'b1, -1, "R9 mode3 edge");
    // R4: high address bytes nonzero, low byte inside the area
    xfer(8'h4B, 24'h010001, 2, 1'b0, 1'b1, -1, "R4 high addr");
    // R7: busy during the opcode
    busy = 1'b1;
    xfer(8'h4B, 24'h000000, 2, 1'b0, 1'b0, -1, "R7 busy");
    busy = 1'b0;
    // R8: wrong opcode
    xfer(8'h0B, 24'h000000, 2, 1'b1, 1'b0, -1, "R8 opcode");
    // R6: abort mid-byte then a clean read
    xfer(8'h4B, 24'h000020, 3, 1'b1, 1'b1, 12, "R6 abort");
    xfer(8'h4B, 24'h000020, 2, 1'b0, 1'b1, -1, "R6 after abort");
    // R4: last valid byte then the first byte beyond
    xfer(8'h4B, 24'h000040, 2, 1'b0, 1'b1, -1, "R4 last byte");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule